// File: doc/BRIEF.md
# Fault isolation register bank

This block holds the fault-tracking and window-configuration registers of one I/O unit behind a simple 64-bit register-access bus. Software reaches every register through an 8-byte-aligned address. Hardware raises faults by pulsing bits of a fault vector, and the block keeps them in a fault register until software clears them. A mask register selects which faults are hidden, and an attention output goes high whenever an unhidden fault is pending. Two action registers and a sticky fault-capture register sit next to them for the fault handler.

A second group holds a window-enable register and six base/mask registers for two memory windows, a register window and an interrupt window. While a window is enabled its base registers are locked: a write to one is dropped and flagged. A mode register and a page-layout register complete the bank. Every implemented register reads back its stored value. Any other offset reads zero, drops writes, and is flagged.

Registers use MSB-first bit numbering: field bit n is data bit 63-n.

Top module: `fbr_regbank`

## Requirements
- R1: The register offset is req_addr shifted right by 3; req_addr[2:0] has no effect. Offsets: 0 fault, 1 fault-AND, 2 fault-OR, 3 mask, 4 mask-AND, 5 mask-OR, 6 action0, 7 action1, 8 capture, 9 mode, 10 page layout, 11 window enable, 12 mem0 base, 13 mem0 mask, 14 mem1 base, 15 mem1 mask, 16 register-window base, 17 interrupt-window base.
- R2: A read (req_valid high, req_write low) gives rsp_valid high in the next cycle, with rsp_rdata holding the stored value. The AND/OR offsets read the register they modify. rsp_valid is low otherwise, and all registers reset to zero.
- R3: A direct write to the fault, mask, action0 or action1 register keeps field bits 0..27 (data[63:36]) and stores zero elsewhere.
- R4: A write to fault-AND (mask-AND) ANDs the data into the fault (mask) register. A write to fault-OR (mask-OR) ORs the data, limited to bits 0..27, into it.
- R5: A write to the capture register clears it, whatever the data. fault_in bits also accumulate into it, limited to bits 0..27.
- R6: fault_in[k] sets fault field bit k (data bit 63-k) at every clock edge, after any register write in the same cycle.
- R7: attn is high exactly when the fault register has a bit set that the mask register does not have set.
- R8: The window-enable register keeps field bits 0..3. Bit 0 enables mem0, bit 1 mem1, bit 2 the register window and bit 3 the interrupt window.
- R9: The mem base and mask registers keep bits 0..39, the register-window base keeps bits 0..41, and the interrupt-window base keeps bits 0..27.
- R10: A write to a base or mask register whose window is enabled leaves it unchanged, and bar_wr_err pulses high in the next cycle.
- R11: The mode register keeps bits 0..7, and the page-layout register keeps bits 3..5 only.
- R12: An access to offsets 18..31 changes no register, reads back zero, and pulses unimpl_access high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 64 | Write data |
| fault_in | input | 28 | Hardware fault vector, bit k sets fault field bit k |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| attn | output | 1 | Unmasked fault pending |
| bar_wr_err | output | 1 | Refused write to a locked base register |
| unimpl_access | output | 1 | Access to an unimplemented offset |

## Verification
The assertions assume at most one request per cycle, so a read and a write never overlap. They also assume fault_in is driven to a known value in every cycle. The bench issues exactly one operation per clock, driven at the falling edge, and holds fault_in at zero except in the cycles that inject faults. It mixes aligned and misaligned addresses, writes to locked and unlocked windows, and same-cycle faults with clearing writes, so that each ordering rule is exercised.

// File: rtl/fbr_pkg.sv
// Package for the fault isolation register bank.
// Holds the register offsets, the decoded write-select struct and the
// MSB-first field-mask helper. Assumes 64-bit registers.
package fbr_pkg;

    localparam int REG_W = 64;

    localparam int OFF_FIR      = 0;
    localparam int OFF_FIR_AND  = 1;
    localparam int OFF_FIR_OR   = 2;
    localparam int OFF_MSK      = 3;
    localparam int OFF_MSK_AND  = 4;
    localparam int OFF_MSK_OR   = 5;
    localparam int OFF_ACT0     = 6;
    localparam int OFF_ACT1     = 7;
    localparam int OFF_CAP      = 8;
    localparam int OFF_MODE     = 9;
    localparam int OFF_PAGE     = 10;
    localparam int OFF_WIN_EN   = 11;
    localparam int OFF_BAR_BASE = 12;
    localparam int NUM_BARS     = 6;
    localparam int NUM_OFFS     = OFF_BAR_BASE + NUM_BARS;

    // Decoded write strobes, one per storage action
    typedef struct packed {
        logic                fir_wr;
        logic                fir_and;
        logic                fir_or;
        logic                msk_wr;
        logic                msk_and;
        logic                msk_or;
        logic                act0_wr;
        logic                act1_wr;
        logic                cap_wr;
        logic                mode_wr;
        logic                page_wr;
        logic                en_wr;
        logic [NUM_BARS-1:0] bar_wr;
    } wsel_t;

    // Field mask covering MSB-first bits first..last
    function automatic logic [REG_W-1:0] msb_field(input int first, input int last);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= first && i <= last) m[REG_W-1-i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fbr_decode.sv
// Address decoder for the register bank.
// Turns one request into write strobes and an implemented-offset flag.
// Assumes at most one request per cycle; offset is the word index.
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int OFF_W = 5
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] offset,
    output wsel_t            wsel,
    output logic             hit
);

    localparam int MAX_OFF = (1 << OFF_W) - 1;

    // Implemented offsets are the low contiguous range
    always_comb hit = (int'(offset) < NUM_OFFS);

    // One strobe per written offset, qualified by a valid write
    always_comb begin
        logic wr;
        wr = req_valid && req_write;
        wsel = '0;
        wsel.fir_wr  = wr && (int'(offset) == OFF_FIR);
        wsel.fir_and = wr && (int'(offset) == OFF_FIR_AND);
        wsel.fir_or  = wr && (int'(offset) == OFF_FIR_OR);
        wsel.msk_wr  = wr && (int'(offset) == OFF_MSK);
        wsel.msk_and = wr && (int'(offset) == OFF_MSK_AND);
        wsel.msk_or  = wr && (int'(offset) == OFF_MSK_OR);
        wsel.act0_wr = wr && (int'(offset) == OFF_ACT0);
        wsel.act1_wr = wr && (int'(offset) == OFF_ACT1);
        wsel.cap_wr  = wr && (int'(offset) == OFF_CAP);
        wsel.mode_wr = wr && (int'(offset) == OFF_MODE);
        wsel.page_wr = wr && (int'(offset) == OFF_PAGE);
        wsel.en_wr   = wr && (int'(offset) == OFF_WIN_EN);
        for (int b = 0; b < NUM_BARS; b++) begin
            wsel.bar_wr[b] = wr && (int'(offset) == OFF_BAR_BASE + b);
        end
    end

    // Compile-time sanity: offset space must hold every register
    initial begin
        if (MAX_OFF < NUM_OFFS - 1) $error("offset space too small");
    end

endmodule

// File: rtl/fbr_fir_group.sv
// Fault group: fault register, mask, two action registers, capture register.
// Faults from hardware OR in after any same-cycle write; attn flags any
// fault bit left uncovered by the mask. Bits are MSB-first.
module fbr_fir_group
    import fbr_pkg::*;
#(
    parameter int FIR_BITS = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wsel_t               wsel,
    input  logic [REG_W-1:0]    wdata,
    input  logic [FIR_BITS-1:0] fault_in,
    output logic [REG_W-1:0]    fir_q,
    output logic [REG_W-1:0]    msk_q,
    output logic [REG_W-1:0]    act0_q,
    output logic [REG_W-1:0]    act1_q,
    output logic [REG_W-1:0]    cap_q,
    output logic                attn
);

    localparam logic [REG_W-1:0] KEEP = msb_field(0, FIR_BITS - 1);

    logic [REG_W-1:0] fault_v;
    logic [REG_W-1:0] fir_d, msk_d;
    logic [REG_W-1:0] kdata;

    // Spread the fault vector onto MSB-first bit positions
    generate
        for (genvar k = 0; k < REG_W; k++) begin : g_fault_map
            if (k < FIR_BITS) begin : g_live
                assign fault_v[REG_W-1-k] = fault_in[k];
            end else begin : g_dead
                assign fault_v[REG_W-1-k] = 1'b0;
            end
        end
    endgenerate

    // Write data limited to the fault field
    always_comb kdata = wdata & KEEP;

    // Next fault value: write/alias result first, hardware faults on top
    always_comb begin
        fir_d = fir_q;
        if (wsel.fir_wr)       fir_d = kdata;
        else if (wsel.fir_and) fir_d = fir_q & wdata;
        else if (wsel.fir_or)  fir_d = fir_q | kdata;
        fir_d = fir_d | fault_v;
    end

    // Next mask value from direct write or its aliases
    always_comb begin
        msk_d = msk_q;
        if (wsel.msk_wr)       msk_d = kdata;
        else if (wsel.msk_and) msk_d = msk_q & wdata;
        else if (wsel.msk_or)  msk_d = msk_q | kdata;
    end

    // Storage of the five fault-group registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fir_q  <= '0;
            msk_q  <= '0;
            act0_q <= '0;
            act1_q <= '0;
            cap_q  <= '0;
        end else begin
            fir_q <= fir_d;
            msk_q <= msk_d;
            if (wsel.act0_wr) act0_q <= kdata;
            if (wsel.act1_wr) act1_q <= kdata;
            cap_q <= (wsel.cap_wr ? '0 : cap_q) | fault_v;
        end
    end

    // Attention whenever an unmasked fault is held
    always_comb attn = |(fir_q & ~msk_q);

    AST_FIR_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fir_q & ~KEEP) == '0);  // R3
    AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> ((fir_q & $past(fault_v)) == $past(fault_v)));  // R6
    AST_CAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel.cap_wr && fault_in == '0) |=> (cap_q == '0));  // R5
    AST_MASK_OR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.msk_or |=> ((msk_q & $past(msk_q)) == $past(msk_q)));  // R4

endmodule

// File: rtl/fbr_bar_group.sv
// Window group: window-enable, six base/mask registers, mode and page layout.
// A base write while its window is enabled is dropped and flagged one
// cycle later. Bits are MSB-first.
module fbr_bar_group
    import fbr_pkg::*;
#(
    parameter int EN_BITS     = 4,
    parameter int MEM_BITS    = 40,
    parameter int REGW_BITS   = 42,
    parameter int INTW_BITS   = 28,
    parameter int MODE_BITS   = 8,
    parameter int PAGE_FIRST  = 3,
    parameter int PAGE_LAST   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wsel_t            wsel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] mode_q,
    output logic [REG_W-1:0] page_q,
    output logic [REG_W-1:0] bar_q [NUM_BARS],
    output logic             bar_err
);

    localparam logic [REG_W-1:0] EN_KEEP   = msb_field(0, EN_BITS - 1);
    localparam logic [REG_W-1:0] MODE_KEEP = msb_field(0, MODE_BITS - 1);
    localparam logic [REG_W-1:0] PAGE_KEEP = msb_field(PAGE_FIRST, PAGE_LAST);

    logic [NUM_BARS-1:0] locked;

    // Per-base storage: field width and guarding enable bit by position
    generate
        for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
            localparam int WBITS = (b < 4) ? MEM_BITS : ((b == 4) ? REGW_BITS : INTW_BITS);
            localparam int EBIT  = (b < 4) ? (b / 2) : (b - 2);
            localparam logic [REG_W-1:0] KEEP = msb_field(0, WBITS - 1);

            // Window currently enabled for this base
            always_comb locked[b] = en_q[REG_W-1-EBIT];

            // Store the base unless its window is enabled
            always_ff @(posedge clk) begin
                if (!rst_n)                           bar_q[b] <= '0;
                else if (wsel.bar_wr[b] && !locked[b]) bar_q[b] <= wdata & KEEP;
            end

            AST_BAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                (wsel.bar_wr[b] && locked[b]) |=> $stable(bar_q[b]));  // R10
        end
    endgenerate

    // Enable, mode and page-layout storage plus refused-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            mode_q  <= '0;
            page_q  <= '0;
            bar_err <= 1'b0;
        end else begin
            if (wsel.en_wr)   en_q   <= wdata & EN_KEEP;
            if (wsel.mode_wr) mode_q <= wdata & MODE_KEEP;
            if (wsel.page_wr) page_q <= wdata & PAGE_KEEP;
            bar_err <= |(wsel.bar_wr & locked);
        end
    end

    AST_PAGE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (page_q & ~PAGE_KEEP) == '0);  // R11
    AST_ERR_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bar_err |-> $past(|wsel.bar_wr));  // R10

endmodule

// File: rtl/fbr_regbank.sv
// Top of the fault isolation register bank.
// Decodes the bus, hosts the fault and window groups, returns registered
// read data one cycle after a read and flags unimplemented offsets.
// Assumes one request per cycle.
module fbr_regbank
    import fbr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FIR_BITS = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [REG_W-1:0]    req_wdata,
    input  logic [FIR_BITS-1:0] fault_in,
    output logic                rsp_valid,
    output logic [REG_W-1:0]    rsp_rdata,
    output logic                attn,
    output logic                bar_wr_err,
    output logic                unimpl_access
);

    localparam int OFF_W = ADDR_W - 3;

    logic [OFF_W-1:0] offset;
    wsel_t            wsel;
    logic             hit;
    logic [REG_W-1:0] fir_q, msk_q, act0_q, act1_q, cap_q;
    logic [REG_W-1:0] en_q, mode_q, page_q;
    logic [REG_W-1:0] bar_q [NUM_BARS];
    logic [REG_W-1:0] rd_mux;

    // Word index from the byte address
    always_comb offset = req_addr[ADDR_W-1:3];

    fbr_decode #(.OFF_W(OFF_W)) i_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .offset    (offset),
        .wsel      (wsel),
        .hit       (hit)
    );

    fbr_fir_group #(.FIR_BITS(FIR_BITS)) i_fir (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsel     (wsel),
        .wdata    (req_wdata),
        .fault_in (fault_in),
        .fir_q    (fir_q),
        .msk_q    (msk_q),
        .act0_q   (act0_q),
        .act1_q   (act1_q),
        .cap_q    (cap_q),
        .attn     (attn)
    );

    fbr_bar_group i_bar (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel    (wsel),
        .wdata   (req_wdata),
        .en_q    (en_q),
        .mode_q  (mode_q),
        .page_q  (page_q),
        .bar_q   (bar_q),
        .bar_err (bar_wr_err)
    );

    // Read selection; aliases return the register they modify
    always_comb begin
        rd_mux = '0;
        case (int'(offset))
            OFF_FIR, OFF_FIR_AND, OFF_FIR_OR: rd_mux = fir_q;
            OFF_MSK, OFF_MSK_AND, OFF_MSK_OR: rd_mux = msk_q;
            OFF_ACT0:   rd_mux = act0_q;
            OFF_ACT1:   rd_mux = act1_q;
            OFF_CAP:    rd_mux = cap_q;
            OFF_MODE:   rd_mux = mode_q;
            OFF_PAGE:   rd_mux = page_q;
            OFF_WIN_EN: rd_mux = en_q;
            default: begin
                for (int b = 0; b < NUM_BARS; b++) begin
                    if (int'(offset) == OFF_BAR_BASE + b) rd_mux = bar_q[b];
                end
            end
        endcase
    end

    // Registered response and unimplemented-access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            unimpl_access <= 1'b0;
        end else begin
            rsp_valid     <= req_valid && !req_write;
            rsp_rdata     <= (req_valid && !req_write) ? rd_mux : '0;
            unimpl_access <= req_valid && !hit;
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bar_wr_err, unimpl_access}));  // R12
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);  // R2
    AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (unimpl_access && rsp_valid) |-> (rsp_rdata == '0));  // R12

endmodule

// File: tb/test_fbr_regbank.sv
// Bench: behavioural reference model of the register bank, updated per
// operation and compared with the outputs every cycle.
module test_fbr_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [27:0] fault_in = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        attn;
    logic        bar_wr_err;
    logic        unimpl_access;

    always #2.5 clk = ~clk;

    fbr_regbank i_fbr_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .fault_in(fault_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .attn(attn),
        .bar_wr_err(bar_wr_err), .unimpl_access(unimpl_access)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] mdl [0:17];
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    // Field mask for MSB-first bits a..b
    function automatic logic [63:0] fld(input int a, input int b);
        logic [63:0] m = '0;
        for (int i = a; i <= b; i++) m[63-i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: model the expected outcome, clock it, compare
    task automatic step(input bit v, input bit w, input int off, input logic [63:0] d,
                        input logic [27:0] f, input int lo, input string tag);
        logic [63:0] k28, fb, e_rd;
        bit e_err, e_unimpl, e_rv;
        int src, ebit;
        k28 = fld(0, 27);
        fb = '0;
        for (int k = 0; k < 28; k++) fb[63-k] = f[k];
        e_rd = '0; e_err = 0; e_unimpl = v && (off >= 18); e_rv = v && !w;
        if (v && !w && off < 18) begin
            src = (off == 1 || off == 2) ? 0 : ((off == 4 || off == 5) ? 3 : off);
            e_rd = mdl[src];
        end
        if (v && w && off < 18) begin
            case (off)
                0: mdl[0] = d & k28;
                1: mdl[0] = mdl[0] & d;
                2: mdl[0] = mdl[0] | (d & k28);
                3: mdl[3] = d & k28;
                4: mdl[3] = mdl[3] & d;
                5: mdl[3] = mdl[3] | (d & k28);
                6, 7: mdl[off] = d & k28;
                8: mdl[8] = '0;
                9: mdl[9] = d & fld(0, 7);
                10: mdl[10] = d & fld(3, 5);
                11: mdl[11] = d & fld(0, 3);
                default: begin
                    ebit = (off < 16) ? (off - 12) / 2 : off - 14;
                    if (mdl[11][63-ebit]) e_err = 1;
                    else mdl[off] = d & ((off < 16) ? fld(0, 39) : ((off == 16) ? fld(0, 41) : k28));
                end
            endcase
        end
        mdl[0] = mdl[0] | fb;
        mdl[8] = mdl[8] | fb;
        req_valid = v; req_write = w; req_addr = 8'(off * 8 + lo);
        req_wdata = d; fault_in = f;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'(e_rv));
        if (e_rv) chk({tag, " R2 rdata"}, rsp_rdata, e_rd);
        chk({tag, " R10 bar_wr_err"}, 64'(bar_wr_err), 64'(e_err));
        chk({tag, " R12 unimpl_access"}, 64'(unimpl_access), 64'(e_unimpl));
        chk({tag, " R7 attn"}, 64'(attn), 64'(|(mdl[0] & ~mdl[3])));
        req_valid = 0; fault_in = '0;
    endtask

    task automatic wr(input int off, input logic [63:0] d, input string tag);
        step(1, 1, off, d, '0, 0, tag);
    endtask

    task automatic rd(input int off, input string tag);
        step(1, 0, off, '0, '0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        for (int i = 0; i < 18; i++) mdl[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: outputs low and every offset reads zero (R2, R12)
        chk("reset R7 attn", 64'(attn), 64'd0);
        chk("reset R2 rsp_valid", 64'(rsp_valid), 64'd0);
        for (int o = 0; o < 32; o++) rd(o, "reset_read");
        // Base widths before any window is enabled (R9)
        for (int o = 12; o < 18; o++) begin wr(o, '1, "R9_width"); rd(o, "R9_readback"); end
        // Field limits of the other registers (R3, R8, R11), unmasked faults raise attn (R7)
        for (int o = 0; o < 12; o++) begin wr(o, '1, "R3_R8_R11_width"); rd(o, "R3_R8_R11_readback"); end
        // AND/OR aliases (R4)
        wr(1, 64'h0F0F_0000_FFFF_FFFF, "R4_fir_and"); rd(0, "R4_fir");
        wr(2, 64'hA000_0000_0000_0000, "R4_fir_or"); rd(2, "R4_fir_alias_read");
        wr(4, 64'hFFFF_F000_0000_0000, "R4_msk_and"); rd(3, "R4_msk");
        wr(5, '1, "R4_msk_or"); rd(5, "R4_msk_alias_read R7");
        // Locked windows refuse writes (R10), then unlocked accept them
        for (int o = 12; o < 18; o++) begin wr(o, 64'h1234_5678_0000_0000, "R10_locked"); rd(o, "R10_unchanged"); end
        wr(11, 64'h5000_0000_0000_0000, "R8_partial_enable");
        for (int o = 12; o < 18; o++) begin wr(o, 64'hCAFE_F00D_1234_5678, "R10_mixed"); rd(o, "R10_mixed_read"); end
        wr(11, '0, "R8_disable");
        // Address low bits have no effect (R1)
        step(1, 1, 9, 64'h8100_0000_0000_0000, '0, 5, "R1_misaligned_write");
        step(1, 0, 9, '0, '0, 7, "R1_misaligned_read");
        // Faults win over a same-cycle clear (R6); capture clears on write (R5)
        wr(3, '0, "R6_unmask");
        step(1, 1, 1, '0, 28'h800_0001, 0, "R6_fault_vs_and_clear");
        rd(0, "R6_fir"); rd(8, "R5_capture");
        wr(8, '1, "R5_capture_clear"); rd(8, "R5_capture_zero");
        step(1, 1, 8, '0, 28'h000_0010, 0, "R5_clear_with_fault"); rd(8, "R5_capture_fault");
        // Unimplemented offsets: write dropped, reads zero (R12)
        wr(20, '1, "R12_unimpl_write"); rd(20, "R12_unimpl_read");
        for (int o = 0; o < 18; o++) rd(o, "R12_bank_intact");
        // Pseudo-random traffic compared every cycle
        for (int n = 0; n < 600; n++) begin
            logic [63:0] r;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            r = lfsr;
            step(r[0] | r[1], r[2], int'(r[9:5]) % ((r[3]) ? 32 : 18),
                 {r[31:0], r[63:32]}, (r[10] && r[11] && r[12]) ? r[40:13] : '0,
                 int'(r[50:48]), "random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule